// File: doc/BRIEF.md
# Reset Strap Configuration Register

This block takes a snapshot of the board's strap levels when reset is released. Those levels sit on a 24-bit expansion address input. The block keeps them in a 32-bit configuration word. Software reads the whole word at any time and may rewrite every part of it except the core speed field.

The stored word drives several outputs:
- a live memory-map remap select;
- a core speed in MHz;
- three PCI mode flags;
- the boot device data width;
- a 4-bit board user code.

The remap select also drives a combinational decode of a 32-bit bus address. That decode tells whether the address falls in the expansion window or in the SDRAM region.

The strap pins are sampled at the first rising clock edge after the active-low reset goes high. This happens exactly once per reset. A parameter gives the factory-rated core speed, and that speed decides which speed patterns are legal. An illegal pattern falls back to the factory speed and sets a sticky error flag.

Top module: `strap_cfg_reg`

## Requirements
- R1: While rstN is low, rdData reads 0x80000000, remapSel is 1, coreMhz equals the factory speed and speedErr is 0.
- R2: At the first rising clock edge with rstN high, rdData[23:0] takes strapAddr[23:0] and rdData[31:24] becomes 0x80. The new value is visible after that edge.
- R3: After that capture, changes on strapAddr never alter rdData.
- R4: A write (wrEn high at a clock edge after capture) loads wrData into every bit except bits [23:21], which keep their captured value. A write presented in the capture cycle is ignored.
- R5: remapSel equals bit 31 of the register. It takes the written value on the cycle after a write.
- R6: The window decode depends on remapSel.
  - With remapSel = 1, expSel is high for busAddr in 0x00000000..0x0FFFFFFF and sdramSel is low.
  - With remapSel = 0, expSel is high for 0x50000000..0x5FFFFFFF and sdramSel is high for 0x00000000..0x0FFFFFFF.
  - Elsewhere both outputs are low, and the two are never high together.
- R7: With a 533 MHz factory speed, bits [23:21] set coreMhz as follows: 3'b100 gives 533, 3'b001 gives 400 and 3'b011 gives 266. With 400 MHz only 3'b100 (400) and 3'b011 (266) are legal. With 266 MHz only 3'b100 is legal.
- R8: An illegal captured speed pattern gives coreMhz equal to the factory speed and raises speedErr from the capture edge on. speedErr then stays high until the next reset.
- R9: pci66 follows bit 4 (1 = 66 MHz, 0 = 33 MHz). pciArbEn follows bit 2 and pciHost follows bit 1. bootWidth8 follows bit 0 (1 = 8-bit, 0 = 16-bit).
- R10: userField follows bits [20:17]. This gives 16 board codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset; its release triggers strap capture |
| strapAddr | input | 24 | Expansion address lines carrying the strap levels |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Current register contents |
| busAddr | input | 32 | Address to decode against the memory map |
| expSel | output | 1 | busAddr falls in the expansion window |
| sdramSel | output | 1 | busAddr falls in the low SDRAM region |
| remapSel | output | 1 | Expansion window is mapped at address zero |
| coreMhz | output | 10 | Selected core speed in MHz |
| speedErr | output | 1 | Sticky flag for an illegal speed pattern |
| pci66 | output | 1 | PCI 66 MHz mode |
| pciArbEn | output | 1 | PCI internal arbiter enabled |
| pciHost | output | 1 | PCI controller acts as host |
| bootWidth8 | output | 1 | Boot device data bus is 8 bits wide |
| userField | output | 4 | Board user code |

## Verification
The bench goes after several corner cases:
- A write landing in the very capture cycle. A design that let it win would read back the write data instead of the straps.
- Strap pins toggling long after boot. A design that kept sampling would drift with the pins.
- A write of all ones and all zeros. A design with a wrong write mask would either corrupt the speed field or freeze a writable field.
- Addresses exactly at both edges of each window, before and after clearing the remap bit. These expose off-by-one window decodes and a stale remap select.
- Repeated resets with legal and illegal speed patterns. A flag that is not sticky, or that survives reset, shows up there.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

  localparam int MHZ_W     = 10;
  localparam int SPD_HI    = 23;
  localparam int SPD_LO    = 21;
  localparam int USER_HI   = 20;
  localparam int USER_LO   = 17;
  localparam int PCI66_BIT = 4;
  localparam int ARB_BIT   = 2;
  localparam int HOST_BIT  = 1;
  localparam int WIDTH_BIT = 0;

  localparam logic [31:0] BOOT_WIN_BASE = 32'h0000_0000;
  localparam logic [31:0] NORM_WIN_BASE = 32'h5000_0000;
  localparam logic [31:0] SDRAM_BASE    = 32'h0000_0000;
  localparam logic [31:0] WIN_SPAN      = 32'h1000_0000;

  // strobes issued by the control to the datapath
  typedef struct packed {
    logic capture;
    logic write;
  } cfgStrobeT;

  typedef struct packed {
    logic             ok;
    logic [MHZ_W-1:0] mhz;
  } speedDecT;

  function automatic logic [31:0] fieldMask(input int hi, input int lo);
    logic [31:0] m;
    m = '0;
    for (int i = lo; i <= hi; i++) m[i] = 1'b1;
    return m;
  endfunction

  // legal patterns depend on the factory rating; anything else falls back
  function automatic speedDecT decodeSpeed(input logic [2:0] pat, input int factory);
    speedDecT d;
    d.ok  = 1'b0;
    d.mhz = MHZ_W'(factory);
    case (pat)
      3'b100: d.ok = 1'b1;
      3'b001: if (factory == 533) begin
        d.ok  = 1'b1;
        d.mhz = MHZ_W'(400);
      end
      3'b011: if (factory >= 400) begin
        d.ok  = 1'b1;
        d.mhz = MHZ_W'(266);
      end
      default: d.ok = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/strap_cfg_ctrl.sv
module strap_cfg_ctrl
  import strap_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  output cfgStrobeT strobe
);

  logic bootedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bootedQ <= 1'b0;
    else       bootedQ <= 1'b1;
  end

  // capture once on the first edge after release; writes only afterwards
  always_comb begin
    strobe.capture = !bootedQ;
    strobe.write   = wrEn && bootedQ;
  end

endmodule

// File: rtl/strap_cfg_dp.sv
module strap_cfg_dp
  import strap_cfg_pkg::*;
#(
  parameter int CFG_W       = 32,
  parameter int STRAP_W     = 24,
  parameter int BUS_W       = 32,
  parameter int FACTORY_MHZ = 533
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobeT          strobe,
  input  logic [STRAP_W-1:0] strapAddr,
  input  logic [CFG_W-1:0]   wrData,
  input  logic [BUS_W-1:0]   busAddr,
  output logic [CFG_W-1:0]   cfgOut,
  output logic               remapSel,
  output logic               expSel,
  output logic               sdramSel,
  output logic [MHZ_W-1:0]   coreMhz,
  output logic               speedErr,
  output logic               pci66,
  output logic               pciArbEn,
  output logic               pciHost,
  output logic               bootWidth8,
  output logic [USER_HI-USER_LO:0] userField
);

  localparam int REMAP_BIT = CFG_W - 1;
  localparam logic [CFG_W-1:0] RESET_VAL = CFG_W'(1) << REMAP_BIT;
  localparam logic [CFG_W-1:0] WR_MASK   = ~CFG_W'(fieldMask(SPD_HI, SPD_LO));

  logic [CFG_W-1:0] cfgQ;
  logic             errQ;
  speedDecT         heldDec;
  speedDecT         pinDec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= RESET_VAL;
    end else if (strobe.capture) begin
      cfgQ <= RESET_VAL | {{(CFG_W-STRAP_W){1'b0}}, strapAddr};
    end else if (strobe.write) begin
      cfgQ <= (wrData & WR_MASK) | (cfgQ & ~WR_MASK);
    end
  end

  always_comb begin
    heldDec = decodeSpeed(cfgQ[SPD_HI:SPD_LO], FACTORY_MHZ);
    pinDec  = decodeSpeed(strapAddr[SPD_HI:SPD_LO], FACTORY_MHZ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               errQ <= 1'b0;
    else if (strobe.capture) errQ <= errQ | !pinDec.ok;
  end

  function automatic logic inWin(input logic [BUS_W-1:0] a, input logic [31:0] base);
    logic [BUS_W-1:0] off;
    off = a - BUS_W'(base);
    return off < BUS_W'(WIN_SPAN);
  endfunction

  always_comb begin
    remapSel = cfgQ[REMAP_BIT];
    if (remapSel) begin
      expSel   = inWin(busAddr, BOOT_WIN_BASE);
      sdramSel = 1'b0;
    end else begin
      expSel   = inWin(busAddr, NORM_WIN_BASE);
      sdramSel = inWin(busAddr, SDRAM_BASE);
    end
  end

  assign cfgOut     = cfgQ;
  assign coreMhz    = heldDec.mhz;
  assign speedErr   = errQ;
  assign pci66      = cfgQ[PCI66_BIT];
  assign pciArbEn   = cfgQ[ARB_BIT];
  assign pciHost    = cfgQ[HOST_BIT];
  assign bootWidth8 = cfgQ[WIDTH_BIT];
  assign userField  = cfgQ[USER_HI:USER_LO];

endmodule

// File: rtl/strap_cfg_reg.sv
module strap_cfg_reg
  import strap_cfg_pkg::*;
#(
  parameter int CFG_W       = 32,
  parameter int STRAP_W     = 24,
  parameter int BUS_W       = 32,
  parameter int FACTORY_MHZ = 533
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] strapAddr,
  input  logic               wrEn,
  input  logic [CFG_W-1:0]   wrData,
  output logic [CFG_W-1:0]   rdData,
  input  logic [BUS_W-1:0]   busAddr,
  output logic               expSel,
  output logic               sdramSel,
  output logic               remapSel,
  output logic [MHZ_W-1:0]   coreMhz,
  output logic               speedErr,
  output logic               pci66,
  output logic               pciArbEn,
  output logic               pciHost,
  output logic               bootWidth8,
  output logic [3:0]         userField
);

  cfgStrobeT strobe;

  strap_cfg_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .strobe (strobe)
  );

  strap_cfg_dp #(
    .CFG_W       (CFG_W),
    .STRAP_W     (STRAP_W),
    .BUS_W       (BUS_W),
    .FACTORY_MHZ (FACTORY_MHZ)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .strapAddr  (strapAddr),
    .wrData     (wrData),
    .busAddr    (busAddr),
    .cfgOut     (rdData),
    .remapSel   (remapSel),
    .expSel     (expSel),
    .sdramSel   (sdramSel),
    .coreMhz    (coreMhz),
    .speedErr   (speedErr),
    .pci66      (pci66),
    .pciArbEn   (pciArbEn),
    .pciHost    (pciHost),
    .bootWidth8 (bootWidth8),
    .userField  (userField)
  );

endmodule

// File: rtl/strap_cfg_chk.sv
module strap_cfg_chk (
  input logic        clk,
  input logic        rstN,
  input logic [23:0] strapAddr,
  input logic        wrEn,
  input logic        wrRemap,
  input logic [31:0] rdData,
  input logic        remapSel,
  input logic        expSel,
  input logic        sdramSel,
  input logic        speedErr
);

  logic bootSeenQ;
  logic rstSeenQ = 1'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bootSeenQ <= 1'b0;
    else       bootSeenQ <= 1'b1;
  end

  always @(posedge clk) begin
    if (!rstN) rstSeenQ <= 1'b1;
  end

  // R1: reset value held while reset is low
  always @(posedge clk) begin
    if (!rstN && rstSeenQ)
      a_r1_reset_value: assert (rdData == 32'h8000_0000 && remapSel && !speedErr)
        else $error("reset value wrong");
  end

  a_r2_capture_pins: assert property (@(posedge clk) disable iff (!rstN)
    !bootSeenQ |=> (rdData[31:24] == 8'h80) && (rdData[23:0] == $past(strapAddr)));

  a_r3_pins_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (bootSeenQ && !wrEn) |=> rdData == $past(rdData));

  a_r4_speed_field_ro: assert property (@(posedge clk) disable iff (!rstN)
    bootSeenQ |=> rdData[23:21] == $past(rdData[23:21]));

  a_r5_remap_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    (bootSeenQ && wrEn) |=> remapSel == $past(wrRemap));

  a_r6_decode_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(expSel && sdramSel));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    speedErr |=> speedErr);

endmodule

bind strap_cfg_reg strap_cfg_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .strapAddr (strapAddr),
  .wrEn      (wrEn),
  .wrRemap   (wrData[31]),
  .rdData    (rdData),
  .remapSel  (remapSel),
  .expSel    (expSel),
  .sdramSel  (sdramSel),
  .speedErr  (speedErr)
);

// File: tb/sim_strap_cfg_reg.sv
`timescale 1ns/1ps
module sim_strap_cfg_reg;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] strapAddr = 24'h96_0012;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] busAddr = '0;
  logic [31:0] rdData;
  logic        expSel, sdramSel, remapSel, speedErr;
  logic        pci66, pciArbEn, pciHost, bootWidth8;
  logic [9:0]  coreMhz;
  logic [3:0]  userField;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  strap_cfg_reg u0 (
    .clk(clk), .rstN(rstN), .strapAddr(strapAddr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .busAddr(busAddr), .expSel(expSel), .sdramSel(sdramSel),
    .remapSel(remapSel), .coreMhz(coreMhz), .speedErr(speedErr), .pci66(pci66),
    .pciArbEn(pciArbEn), .pciHost(pciHost), .bootWidth8(bootWidth8),
    .userField(userField)
  );

  // behavioural reference model
  bit [31:0] mCfg = 32'h8000_0000;
  bit        mBooted = 0;
  bit        mErr = 0;

  function automatic bit legal533(bit [2:0] p);
    return (p == 3'b100) || (p == 3'b001) || (p == 3'b011);
  endfunction

  function automatic int mhz533(bit [2:0] p);
    if (p == 3'b001) return 400;
    if (p == 3'b011) return 266;
    return 533;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCfg = 32'h8000_0000; mBooted = 0; mErr = 0;
    end else if (!mBooted) begin
      mCfg = {8'h80, strapAddr};
      mBooted = 1;
      if (!legal533(strapAddr[23:21])) mErr = 1;
    end else if (wrEn) begin
      mCfg = {wrData[31:24], mCfg[23:21], wrData[20:0]};
    end
  end

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(string tag);
    bit eExp, eSd;
    if (mCfg[31]) begin
      eExp = busAddr < 32'h1000_0000; eSd = 0;
    end else begin
      eExp = busAddr >= 32'h5000_0000 && busAddr < 32'h6000_0000;
      eSd  = busAddr < 32'h1000_0000;
    end
    cmp(tag, "rdData", rdData, mCfg);
    cmp("R5", "remapSel", 32'(remapSel), 32'(mCfg[31]));
    cmp("R6", "expSel", 32'(expSel), 32'(eExp));
    cmp("R6", "sdramSel", 32'(sdramSel), 32'(eSd));
    cmp("R7", "coreMhz", 32'(coreMhz), mBooted ? mhz533(mCfg[23:21]) : 533);
    cmp("R8", "speedErr", 32'(speedErr), 32'(mErr));
    cmp("R9", "pci66", 32'(pci66), 32'(mCfg[4]));
    cmp("R9", "pciArbEn", 32'(pciArbEn), 32'(mCfg[2]));
    cmp("R9", "pciHost", 32'(pciHost), 32'(mCfg[1]));
    cmp("R9", "bootWidth8", 32'(bootWidth8), 32'(mCfg[0]));
    cmp("R10", "userField", 32'(userField), 32'(mCfg[20:17]));
  endtask

  task automatic tick(string tag);
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic doReset(logic [23:0] straps);
    rstN = 1'b0;
    strapAddr = straps;
    tick("R1");
    tick("R1");
    rstN = 1'b1;
    tick("R2");
  endtask

  task automatic sweep(string tag);
    logic [31:0] probes [8] = '{32'h0000_0000, 32'h0FFF_FFFF, 32'h1000_0000, 32'h4FFF_FFFF,
                                32'h5000_0000, 32'h5FFF_FFFF, 32'h6000_0000, 32'hFFFF_FFFF};
    for (int i = 0; i < 8; i++) begin
      busAddr = probes[i];
      tick(tag);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tick("R1");
    tick("R1");
    // R2 capture, with a simultaneous write that must lose (R4)
    rstN = 1'b1;
    wrEn = 1'b1;
    wrData = 32'h0000_0000;
    tick("R2");
    wrEn = 1'b0;
    tick("R4");
    // R3: pin changes after boot are ignored
    strapAddr = 24'h000000; tick("R3");
    strapAddr = 24'hFFFFFF; tick("R3");
    strapAddr = 24'h2A5A5A; tick("R3");
    // R6: decode with remap set
    sweep("R6");
    // R4: all-ones and all-zeros writes leave [23:21]
    wrEn = 1'b1; wrData = 32'hFFFF_FFFF; tick("R4");
    wrEn = 1'b0; tick("R4");
    wrEn = 1'b1; wrData = 32'h0000_0000; tick("R4");
    wrEn = 1'b0; tick("R5");
    // R5/R6: remap cleared, decode moves
    sweep("R6");
    // R9/R10 field patterns
    for (int k = 0; k < 6; k++) begin
      wrEn = 1'b1;
      wrData = {1'b0, 7'h11 * 7'(k), 3'b000, 4'(k * 3), 12'h000, 5'(k * 7)};
      tick("R9");
      wrEn = 1'b0;
      tick("R10");
    end
    // R5: set remap back on
    wrEn = 1'b1; wrData = 32'h8000_0000; tick("R5");
    wrEn = 1'b0; sweep("R5");
    // R7: legal speed patterns
    doReset(24'h3E_0016); tick("R7");
    doReset(24'h7E_0005); tick("R7");
    // R8: illegal pattern, sticky through writes and pin changes
    doReset(24'h5E_0000);
    tick("R8");
    wrEn = 1'b1; wrData = 32'h0000_0000; tick("R8");
    wrEn = 1'b0; strapAddr = 24'h800000; tick("R8");
    tick("R8");
    // reset with legal pattern clears the flag
    doReset(24'h9E_0013);
    tick("R8");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule